// File: doc/BRIEF.md
# Secure-Aware End-of-Interrupt Priority Drop

This block is the completion path of an interrupt-controller CPU interface. It tracks which priority levels are currently active for three interrupt groups: group 0, secure group 1 and non-secure group 1. An acknowledge port marks a level active in one group. Software retires an interrupt by writing one of two completion registers, one for group 0 and one for group 1.

On such a write, the block reads the group of the most urgent active level from its own state. It does not infer the group from the register that was written. It then checks whether the write may retire that group, given the register used, the CPU security state and whether the CPU runs at the top privilege level. When the write passes, the block clears that level in the chosen group's bitmap and raises a one-cycle completion pulse tagged with the group.

A small state machine sequences the pulse. In `ST_IDLE` the done output is low. An accepted write moves the machine to `ST_DONE` (transition `GO_DONE`). From `ST_DONE`, a further accepted write keeps it in `ST_DONE` (transition `STAY_DONE`). Otherwise it returns to `ST_IDLE` (transition `BACK_IDLE`). Reset forces `ST_IDLE`.

Top module: `eoi_prio_drop`

## Requirements
- R1: The interrupt identifier is bits [23:0] of `eoi_data_i`. Bits [31:24] have no effect on the outcome.
- R2: A write whose identifier is equal to or greater than `NUM_IRQ` (default 1020) is ignored. This covers the identifiers 1020 to 1023.
- R3: The most urgent active level is the lowest set level across all three bitmaps. On a tie, group 0 wins over secure group 1, which wins over non-secure group 1. `run_valid_o`, `run_prio_o` and `run_grp_o` present this level and its group, with group codes 0 = group 0, 1 = secure group 1 and 2 = non-secure group 1. The group to complete is always `run_grp_o`.
- R4: A group-0 interrupt completes only through the group-0 register (`eoi_sel_g1_i`=0). It is also refused when `sec_en_i`, `top_impl_i` and a non-secure CPU (`cpu_secure_i`=0) all hold together.
- R5: A secure group-1 interrupt completes only through the group-1 register (`eoi_sel_g1_i`=1), and only while `cpu_secure_i`=1.
- R6: A non-secure group-1 interrupt completes only through the group-1 register. It is refused when the CPU is secure and `cpu_top_el_i`=0. At the top privilege level, both group-1 kinds can be completed.
- R7: An accepted write clears its level in the chosen group at the clock edge that samples it. During the following cycle, `done_o` is high for exactly one cycle and `done_grp_o` carries the group code. A refused write changes nothing.
- R8: With no level active in any group, every write is ignored and `done_o` stays low.
- R9: An acknowledge (`ack_valid_i`) sets the bit for `ack_prio_i` in group `ack_grp_i`, and it is visible from the next cycle. Group code 3 is ignored. When an acknowledge and a drop hit the same bit in one cycle, the bit stays set.
- R10: A synchronous active-low reset clears all bitmaps and the done output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_prio_i | input | 5 | Priority level being activated |
| ack_grp_i | input | 2 | Group of the acknowledged interrupt (0/1/2; 3 ignored) |
| eoi_wr_i | input | 1 | Completion register write strobe |
| eoi_sel_g1_i | input | 1 | 0 = group-0 register, 1 = group-1 register |
| eoi_data_i | input | 32 | Written value; low 24 bits are the identifier |
| cpu_secure_i | input | 1 | CPU is in secure state |
| cpu_top_el_i | input | 1 | CPU runs at the top privilege level |
| sec_en_i | input | 1 | Controller has security enabled |
| top_impl_i | input | 1 | Top privilege level is implemented |
| run_valid_o | output | 1 | Some level is active |
| run_prio_o | output | 5 | Most urgent active level |
| run_grp_o | output | 2 | Group of the most urgent active level |
| done_o | output | 1 | One-cycle completion pulse |
| done_grp_o | output | 2 | Group retired by the pulse |

## Verification
An acknowledge and an accepted completion write can land in the same cycle and target the same level of the same group. The bench activates a non-secure group-1 level, then drives a new acknowledge for that level together with a group-1 completion write from a non-secure CPU. It judges that the done pulse appears with group code 2 while the level is still reported as the running priority. A second coincidence, where an acknowledge of a different level meets a drop, is judged by the running priority that remains afterwards.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } st_e;

    localparam int NUM_GRP = 3;

endpackage

// File: rtl/eoi_active_bank.sv
module eoi_active_bank #(
    parameter int LEVELS = 32,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [LVL_W-1:0]  set_lvl,
    input  logic              clr_en,
    input  logic [LVL_W-1:0]  clr_lvl,
    output logic [LEVELS-1:0] bits_o
);

    logic [LEVELS-1:0] set_mask;
    logic [LEVELS-1:0] clr_mask;

    always_comb begin
        set_mask = set_en ? (LEVELS'(1) << set_lvl) : '0;
        clr_mask = clr_en ? (LEVELS'(1) << clr_lvl) : '0;
    end

    // acknowledge applied after clear so it wins on a shared bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_o <= '0;
        end else begin
            bits_o <= (bits_o & ~clr_mask) | set_mask;
        end
    end

    AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_lvl == clr_lvl) |=> bits_o[$past(set_lvl)]); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_lvl == clr_lvl)) |=> !bits_o[$past(clr_lvl)]); // R7

endmodule

// File: rtl/eoi_prio_resolve.sv
module eoi_prio_resolve
    import eoi_pkg::*;
#(
    parameter int LEVELS = 32,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] bits_g0,
    input  logic [LEVELS-1:0] bits_g1s,
    input  logic [LEVELS-1:0] bits_g1ns,
    output logic              valid_o,
    output logic [LVL_W-1:0]  lvl_o,
    output grp_e              grp_o
);

    // walk from least to most urgent so the lowest set level is kept
    always_comb begin
        valid_o = 1'b0;
        lvl_o   = '0;
        grp_o   = GRP_NONE;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (bits_g0[i] || bits_g1s[i] || bits_g1ns[i]) begin
                valid_o = 1'b1;
                lvl_o   = LVL_W'(i);
                if (bits_g0[i])       grp_o = GRP_G0;
                else if (bits_g1s[i]) grp_o = GRP_G1S;
                else                  grp_o = GRP_G1NS;
            end
        end
    end

    always_comb begin
        AST_GRP_VALID: assert (!valid_o || grp_o != GRP_NONE); // R3
    end

endmodule

// File: rtl/eoi_access_gate.sv
module eoi_access_gate
    import eoi_pkg::*;
(
    input  logic run_valid,
    input  grp_e run_grp,
    input  logic id_ok,
    input  logic sel_g1,
    input  logic cpu_secure,
    input  logic cpu_top_el,
    input  logic sec_en,
    input  logic top_impl,
    output logic allow_o
);

    logic rule_ok;

    always_comb begin
        rule_ok = 1'b0;
        unique case (run_grp)
            GRP_G0:   rule_ok = !sel_g1 && !(sec_en && top_impl && !cpu_secure);
            GRP_G1S:  rule_ok = sel_g1 && cpu_secure;
            GRP_G1NS: rule_ok = sel_g1 && !(cpu_secure && !cpu_top_el);
            GRP_NONE: rule_ok = 1'b0;
        endcase
        allow_o = run_valid && id_ok && rule_ok;
    end

endmodule

// File: rtl/eoi_prio_drop.sv
module eoi_prio_drop
    import eoi_pkg::*;
#(
    parameter int          LEVELS  = 32,
    parameter int          DATA_W  = 32,
    parameter int          ID_W    = 24,
    parameter int unsigned NUM_IRQ = 1020,
    localparam int         LVL_W   = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_valid_i,
    input  logic [LVL_W-1:0]  ack_prio_i,
    input  logic [1:0]        ack_grp_i,
    input  logic              eoi_wr_i,
    input  logic              eoi_sel_g1_i,
    input  logic [DATA_W-1:0] eoi_data_i,
    input  logic              cpu_secure_i,
    input  logic              cpu_top_el_i,
    input  logic              sec_en_i,
    input  logic              top_impl_i,
    output logic              run_valid_o,
    output logic [LVL_W-1:0]  run_prio_o,
    output logic [1:0]        run_grp_o,
    output logic              done_o,
    output logic [1:0]        done_grp_o
);

    logic [LEVELS-1:0] bank_bits [NUM_GRP];
    logic [ID_W-1:0]   irq_id;
    logic              id_ok;
    logic              allow;
    logic              drop_en;
    grp_e              run_grp;
    st_e               state_q;
    st_e               state_d;
    grp_e              done_grp_q;

    assign irq_id  = eoi_data_i[ID_W-1:0];
    assign id_ok   = (32'(irq_id) < NUM_IRQ);
    assign drop_en = eoi_wr_i && allow;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
        eoi_active_bank #(.LEVELS(LEVELS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (ack_valid_i && ack_grp_i == 2'(g)),
            .set_lvl (ack_prio_i),
            .clr_en  (drop_en && run_grp == grp_e'(g)),
            .clr_lvl (run_prio_o),
            .bits_o  (bank_bits[g])
        );
    end

    eoi_prio_resolve #(.LEVELS(LEVELS)) u_resolve (
        .bits_g0   (bank_bits[0]),
        .bits_g1s  (bank_bits[1]),
        .bits_g1ns (bank_bits[2]),
        .valid_o   (run_valid_o),
        .lvl_o     (run_prio_o),
        .grp_o     (run_grp)
    );

    eoi_access_gate u_gate (
        .run_valid  (run_valid_o),
        .run_grp    (run_grp),
        .id_ok      (id_ok),
        .sel_g1     (eoi_sel_g1_i),
        .cpu_secure (cpu_secure_i),
        .cpu_top_el (cpu_top_el_i),
        .sec_en     (sec_en_i),
        .top_impl   (top_impl_i),
        .allow_o    (allow)
    );

    assign run_grp_o = run_grp;

    // next-state: GO_DONE, STAY_DONE, BACK_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = drop_en ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = drop_en ? ST_DONE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            done_grp_q <= GRP_G0;
        end else begin
            state_q <= state_d;
            if (drop_en) done_grp_q <= run_grp;
        end
    end

    always_comb begin
        done_o     = (state_q == ST_DONE);
        done_grp_o = done_grp_q;
    end

    AST_SPURIOUS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_i && 32'(eoi_data_i[ID_W-1:0]) >= NUM_IRQ) |=> !done_o); // R2

    AST_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_i && !run_valid_o) |=> !done_o); // R8

    AST_G0_WRONG_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_i && run_valid_o && run_grp_o == 2'd0 && eoi_sel_g1_i) |=> !done_o); // R4

    AST_G1S_NONSECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_i && run_valid_o && run_grp_o == 2'd1 && !cpu_secure_i) |=> !done_o); // R5

    AST_G1NS_SEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_i && run_valid_o && run_grp_o == 2'd2 && cpu_secure_i && !cpu_top_el_i)
        |=> !done_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o || $past(eoi_wr_i))); // R7

    AST_DONE_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (done_grp_o == $past(run_grp_o))); // R7

endmodule

// File: tb/eoi_prio_drop_tb.sv
module eoi_prio_drop_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_valid_i = 1'b0;
    logic [4:0]  ack_prio_i = '0;
    logic [1:0]  ack_grp_i = '0;
    logic        eoi_wr_i = 1'b0;
    logic        eoi_sel_g1_i = 1'b0;
    logic [31:0] eoi_data_i = '0;
    logic        cpu_secure_i = 1'b0;
    logic        cpu_top_el_i = 1'b0;
    logic        sec_en_i = 1'b0;
    logic        top_impl_i = 1'b0;
    logic        run_valid_o;
    logic [4:0]  run_prio_o;
    logic [1:0]  run_grp_o;
    logic        done_o;
    logic [1:0]  done_grp_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    eoi_prio_drop u_dut (
        .clk(clk), .rst_n(rst_n),
        .ack_valid_i(ack_valid_i), .ack_prio_i(ack_prio_i), .ack_grp_i(ack_grp_i),
        .eoi_wr_i(eoi_wr_i), .eoi_sel_g1_i(eoi_sel_g1_i), .eoi_data_i(eoi_data_i),
        .cpu_secure_i(cpu_secure_i), .cpu_top_el_i(cpu_top_el_i),
        .sec_en_i(sec_en_i), .top_impl_i(top_impl_i),
        .run_valid_o(run_valid_o), .run_prio_o(run_prio_o), .run_grp_o(run_grp_o),
        .done_o(done_o), .done_grp_o(done_grp_o)
    );

    typedef struct packed {
        logic [1:0]  grp;
        logic        sel_g1;
        logic        sec;
        logic        top;
        logic        secen;
        logic        impl;
        logic [31:0] data;
        logic        exp_done;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'd5,        1'b1},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'd5,        1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd5,        1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd5,        1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd5,        1'b1},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'd40,       1'b1},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'd40,       1'b0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'd77,       1'b0},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'd77,       1'b1},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'd77,       1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd77,       1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'd1020,     1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0100_0005, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_ack(input logic [1:0] g, input logic [4:0] p);
        @(negedge clk);
        ack_valid_i = 1'b1; ack_grp_i = g; ack_prio_i = p;
        @(negedge clk);
        ack_valid_i = 1'b0;
    endtask

    // drives a write for one cycle; returns at the negedge where done shows
    task automatic do_eoi(input logic sel, input logic sec, input logic top,
                          input logic [31:0] data);
        @(negedge clk);
        eoi_wr_i = 1'b1; eoi_sel_g1_i = sel; cpu_secure_i = sec;
        cpu_top_el_i = top; eoi_data_i = data;
        @(negedge clk);
        eoi_wr_i = 1'b0;
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        do_reset();
        @(negedge clk);
        chk("R10 run_valid after reset", 32'(run_valid_o), 32'd0);
        chk("R10 done after reset", 32'(done_o), 32'd0);

        // table: one active level, one write, judge the outcome
        for (int i = 0; i < NV; i++) begin
            do_reset();
            sec_en_i = VECS[i].secen;
            top_impl_i = VECS[i].impl;
            do_ack(VECS[i].grp, 5'(i + 3));
            do_eoi(VECS[i].sel_g1, VECS[i].sec, VECS[i].top, VECS[i].data);
            chk($sformatf("R4/R5/R6 row %0d done", i), 32'(done_o), 32'(VECS[i].exp_done));
            if (VECS[i].exp_done)
                chk($sformatf("R7 row %0d group", i), 32'(done_grp_o), 32'(VECS[i].grp));
            chk($sformatf("R7 row %0d level left", i), 32'(run_valid_o),
                32'(!VECS[i].exp_done));
            if (i == 11) chk("R2 spurious id ignored", 32'(done_o), 32'd0);
            if (i == 12) chk("R1 upper bits ignored", 32'(done_o), 32'd1);
        end

        // R7: pulse lasts one cycle
        @(negedge clk);
        chk("R7 done drops after one cycle", 32'(done_o), 32'd0);

        // R3: lowest level wins across groups; group taken from state
        do_reset();
        sec_en_i = 1'b1; top_impl_i = 1'b1;
        do_ack(2'd0, 5'd7);
        do_ack(2'd2, 5'd3);
        chk("R3 run prio", 32'(run_prio_o), 32'd3);
        chk("R3 run grp", 32'(run_grp_o), 32'd2);
        do_eoi(1'b0, 1'b1, 1'b0, 32'd9);
        chk("R3 group-0 register cannot retire g1ns top", 32'(done_o), 32'd0);
        do_eoi(1'b1, 1'b0, 1'b0, 32'd9);
        chk("R3 g1ns retired", 32'(done_o), 32'd1);
        chk("R3 next running prio", 32'(run_prio_o), 32'd7);
        chk("R3 next running grp", 32'(run_grp_o), 32'd0);

        // R3: tie at one level, group 0 first then secure group 1
        do_reset();
        do_ack(2'd2, 5'd4);
        do_ack(2'd1, 5'd4);
        chk("R3 tie g1s over g1ns", 32'(run_grp_o), 32'd1);
        do_ack(2'd0, 5'd4);
        chk("R3 tie g0 first", 32'(run_grp_o), 32'd0);

        // R9: group code 3 ignored
        do_reset();
        do_ack(2'd3, 5'd2);
        chk("R9 group code 3 ignored", 32'(run_valid_o), 32'd0);

        // R8: empty state ignores writes
        do_eoi(1'b1, 1'b1, 1'b1, 32'd1);
        chk("R8 empty write no done", 32'(done_o), 32'd0);

        // R9: acknowledge and drop on the same bit in one cycle
        do_reset();
        sec_en_i = 1'b1; top_impl_i = 1'b1;
        do_ack(2'd2, 5'd3);
        @(negedge clk);
        ack_valid_i = 1'b1; ack_grp_i = 2'd2; ack_prio_i = 5'd3;
        eoi_wr_i = 1'b1; eoi_sel_g1_i = 1'b1; cpu_secure_i = 1'b0;
        cpu_top_el_i = 1'b0; eoi_data_i = 32'd12;
        @(negedge clk);
        ack_valid_i = 1'b0; eoi_wr_i = 1'b0;
        chk("R9 coincident drop pulses", 32'(done_o), 32'd1);
        chk("R9 coincident drop group", 32'(done_grp_o), 32'd2);
        chk("R9 ack wins bit stays", 32'(run_valid_o), 32'd1);
        chk("R9 ack wins prio", 32'(run_prio_o), 32'd3);

        // R9: ack of another level alongside a drop
        @(negedge clk);
        ack_valid_i = 1'b1; ack_grp_i = 2'd1; ack_prio_i = 5'd9;
        eoi_wr_i = 1'b1; eoi_sel_g1_i = 1'b1; cpu_secure_i = 1'b0;
        @(negedge clk);
        ack_valid_i = 1'b0; eoi_wr_i = 1'b0;
        chk("R9 other ack survives drop", 32'(run_prio_o), 32'd9);
        chk("R9 other ack group", 32'(run_grp_o), 32'd1);

        // R10: reset mid-run clears everything
        do_reset();
        @(negedge clk);
        chk("R10 reset clears bitmaps", 32'(run_valid_o), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule